// File: doc/BRIEF.md
# SPI Host Controller with Byte FIFOs

This block is a memory-mapped SPI host. Software talks to it through single-cycle 32-bit register reads and writes. Bytes written to the transmit data register enter an 8-entry transmit FIFO. A byte-wide full-duplex shift engine takes the bytes out of that FIFO one at a time. It drives them MSB first in SPI mode 0 and collects the byte returned on the input line. The returned bytes go into an 8-entry receive FIFO, which software drains through the receive data register.

Two watermark conditions set pending bits: the transmit FIFO running low and the receive FIFO filling up. The interrupt line is raised when a pending bit is set and its enable bit is also set. Chip-select registers pick which select line the engine drives automatically during a byte, and the idle level of every line. Some configuration writes are rejected when the value is out of range. Reserved and unmapped offsets read as zero.

Top module: `spih_top`

## Requirements
- R1: After reset, the clock divider (0x00) reads 3, delay0 (0x28) reads 0x1001, delay1 (0x2C) reads 1, and chip-select default (0x14) reads with one bit set per select line. Every other register reads 0, both FIFOs are empty, irq is low and every select line is high.
- R2: A write to tx data (0x48) pushes bits [7:0] when the transmit FIFO is not full and is dropped otherwise. A read of 0x48 returns 0x8000_0000 while that FIFO holds 8 bytes, and 0 otherwise.
- R3: A read of rx data (0x4C) returns 0x8000_0000 when the receive FIFO is empty. Otherwise it returns the oldest byte, zero-extended, and removes that byte in the same access.
- R4: The shift engine runs SPI mode 0. sclk idles low, mosi carries bit 7 first and changes after falling edges, and miso is sampled on rising edges. Each sclk half-period lasts (divider + 1) clock cycles.
- R5: When bit 3 of the frame format register (0x40) is set, received bytes are discarded. A received byte that finds the receive FIFO full is also dropped.
- R6: In the pending register (0x74), bit 0 is 1 while the transmit count is strictly below the tx mark (0x50). Bit 1 is 1 while the receive count is strictly above the rx mark (0x54).
- R7: irq is high exactly when pending AND enable (0x70, bit 0 for the transmit watermark, bit 1 for the receive watermark) is nonzero.
- R8: Writes of 8 or more to either mark register are ignored. Writes to rx data and to the pending register are ignored. The flash control (0x60) and flash format (0x64) offsets ignore writes and read 0.
- R9: A chip-select id (0x10) write is ignored when the value is not below NUM_CS. A chip-select default write is ignored when the value is 2^NUM_CS or more. A chip-select mode (0x18) write is ignored when the value is above 3.
- R10: Reserved offsets (0x08, 0x0C, 0x1C, 0x20, 0x24, 0x30 to 0x3C, 0x44, 0x58, 0x5C, 0x68, 0x6C) and offsets past 0x74 read 0 and ignore writes.
- R11: In chip-select mode 0, the line named by chip-select id is driven low while a byte is shifting. Every other line, and every line in other modes, follows its chip-select default bit.
- R12: Read data appears on busRdata on the clock edge that accepts the read, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| busValid | input | 1 | Register access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Watermark interrupt |

## Verification
The properties assume that each access is a one-cycle valid strobe. They also assume that the divider is written only while the engine is idle, so a byte keeps one half-period from start to finish. The stimulus follows both rules: every bus task holds busValid for exactly one cycle, and each transfer group waits for the engine to drain before it touches the divider again. miso is looped back from mosi, optionally inverted, so the expected receive bytes follow from the bytes that were sent.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam int BYTE_W = 8;

  localparam logic [11:0] OFF_DIV    = 12'h000;
  localparam logic [11:0] OFF_SMODE  = 12'h004;
  localparam logic [11:0] OFF_CSID   = 12'h010;
  localparam logic [11:0] OFF_CSDEF  = 12'h014;
  localparam logic [11:0] OFF_CSMODE = 12'h018;
  localparam logic [11:0] OFF_DLY0   = 12'h028;
  localparam logic [11:0] OFF_DLY1   = 12'h02C;
  localparam logic [11:0] OFF_FRAME  = 12'h040;
  localparam logic [11:0] OFF_TXD    = 12'h048;
  localparam logic [11:0] OFF_RXD    = 12'h04C;
  localparam logic [11:0] OFF_TXMARK = 12'h050;
  localparam logic [11:0] OFF_RXMARK = 12'h054;
  localparam logic [11:0] OFF_IEN    = 12'h070;
  localparam logic [11:0] OFF_IPEND  = 12'h074;

  localparam int FRAME_RXOFF_BIT = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic              txPush;
    logic [BYTE_W-1:0] txByte;
    logic              rxPop;
  } ctrlStrb_t;
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spih_shifter.sv
module spih_shifter #(
  parameter int DIV_W = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [spih_pkg::BYTE_W-1:0] txByte,
  input  logic [DIV_W-1:0]           sckDiv,
  input  logic                       miso,
  output logic                       busy,
  output logic                       done,
  output logic [spih_pkg::BYTE_W-1:0] rxByte,
  output logic                       sclk,
  output logic                       mosi
);
  import spih_pkg::*;
  localparam int BIT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  halfCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] txSh, rxSh;
  logic              sclkR;

  assign sclk   = sclkR;
  assign mosi   = txSh[BYTE_W-1];
  assign rxByte = rxSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclkR   <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        txSh    <= txByte;
        halfCnt <= '0;
        sclkR   <= 1'b0;
        bitIdx  <= '0;
      end else if (busy) begin
        if (halfCnt >= sckDiv) begin
          halfCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            rxSh  <= {rxSh[BYTE_W-2:0], miso};
          end else begin
            sclkR <= 1'b0;
            if (bitIdx == BIT_W'(BYTE_W-1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              txSh   <= {txSh[BYTE_W-2:0], 1'b0};
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spih_datapath.sv
module spih_datapath #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  spih_pkg::ctrlStrb_t         strb,
  input  logic [DIV_W-1:0]            sckDiv,
  input  logic                        rxDiscard,
  input  logic                        miso,
  output logic                        sclk,
  output logic                        mosi,
  output logic [$clog2(DEPTH+1)-1:0]  txCount,
  output logic [$clog2(DEPTH+1)-1:0]  rxCount,
  output logic                        txFull,
  output logic                        rxEmpty,
  output logic [spih_pkg::BYTE_W-1:0] rxHead,
  output logic                        engBusy,
  output logic                        rxPush
);
  import spih_pkg::*;

  logic [BYTE_W-1:0] txHead, shRxByte;
  logic              txEmpty, rxFull, txPop, shDone;

  assign txPop  = !engBusy && !txEmpty;
  assign rxPush = shDone && !rxDiscard && !rxFull;

  spih_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) uTxFifo (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .din(strb.txByte), .pop(txPop),
    .head(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spih_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) uRxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .din(shRxByte), .pop(strb.rxPop),
    .head(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  spih_shifter #(.DIV_W(DIV_W)) uShift (
    .clk(clk), .rstN(rstN),
    .start(txPop), .txByte(txHead), .sckDiv(sckDiv), .miso(miso),
    .busy(engBusy), .done(shDone), .rxByte(shRxByte),
    .sclk(sclk), .mosi(mosi)
  );
endmodule

// File: rtl/spih_ctrl.sv
module spih_ctrl #(
  parameter int NUM_CS = 2,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 12,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busValid,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [$clog2(DEPTH+1)-1:0]  txCount,
  input  logic [$clog2(DEPTH+1)-1:0]  rxCount,
  input  logic                        txFull,
  input  logic                        rxEmpty,
  input  logic [spih_pkg::BYTE_W-1:0] rxHead,
  input  logic                        engBusy,
  output spih_pkg::ctrlStrb_t         strb,
  output logic [DIV_W-1:0]            sckDiv,
  output logic                        rxDiscard,
  output logic [NUM_CS-1:0]           csN,
  output logic                        irq
);
  import spih_pkg::*;

  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int MARK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CSID_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [DIV_W-1:0]  divR;
  logic [1:0]        sModeR, csModeR, ienR, pendVec;
  logic [CSID_W-1:0] csIdR;
  logic [NUM_CS-1:0] csDefR;
  logic [31:0]       dly0R, dly1R, frameR, rdNext;
  logic [MARK_W-1:0] txMarkR, rxMarkR;
  logic              wrEn, rdEn;

  assign wrEn = busValid && busWrite;
  assign rdEn = busValid && !busWrite;

  assign strb.txPush = wrEn && (busAddr == ADDR_W'(OFF_TXD));
  assign strb.txByte = busWdata[BYTE_W-1:0];
  assign strb.rxPop  = rdEn && (busAddr == ADDR_W'(OFF_RXD));

  assign sckDiv    = divR;
  assign rxDiscard = frameR[FRAME_RXOFF_BIT];

  assign pendVec = {rxCount > CNT_W'(rxMarkR), txCount < CNT_W'(txMarkR)};
  assign irq     = |(pendVec & ienR);

  // register writes with range checks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divR    <= DIV_W'(3);
      sModeR  <= '0;
      csIdR   <= '0;
      csDefR  <= '1;
      csModeR <= '0;
      dly0R   <= 32'h0000_1001;
      dly1R   <= 32'h0000_0001;
      frameR  <= '0;
      txMarkR <= '0;
      rxMarkR <= '0;
      ienR    <= '0;
    end else if (wrEn) begin
      case (busAddr)
        ADDR_W'(OFF_DIV):    divR   <= busWdata[DIV_W-1:0];
        ADDR_W'(OFF_SMODE):  sModeR <= busWdata[1:0];
        ADDR_W'(OFF_CSID):   if (busWdata < 32'(NUM_CS)) csIdR <= busWdata[CSID_W-1:0];
        ADDR_W'(OFF_CSDEF):  if ((busWdata >> NUM_CS) == 32'd0) csDefR <= busWdata[NUM_CS-1:0];
        ADDR_W'(OFF_CSMODE): if (busWdata <= 32'd3) csModeR <= busWdata[1:0];
        ADDR_W'(OFF_DLY0):   dly0R  <= busWdata;
        ADDR_W'(OFF_DLY1):   dly1R  <= busWdata;
        ADDR_W'(OFF_FRAME):  frameR <= busWdata;
        ADDR_W'(OFF_TXMARK): if (busWdata < 32'(DEPTH)) txMarkR <= busWdata[MARK_W-1:0];
        ADDR_W'(OFF_RXMARK): if (busWdata < 32'(DEPTH)) rxMarkR <= busWdata[MARK_W-1:0];
        ADDR_W'(OFF_IEN):    ienR   <= busWdata[1:0];
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdNext = '0;
    case (busAddr)
      ADDR_W'(OFF_DIV):    rdNext = 32'(divR);
      ADDR_W'(OFF_SMODE):  rdNext = 32'(sModeR);
      ADDR_W'(OFF_CSID):   rdNext = 32'(csIdR);
      ADDR_W'(OFF_CSDEF):  rdNext = 32'(csDefR);
      ADDR_W'(OFF_CSMODE): rdNext = 32'(csModeR);
      ADDR_W'(OFF_DLY0):   rdNext = dly0R;
      ADDR_W'(OFF_DLY1):   rdNext = dly1R;
      ADDR_W'(OFF_FRAME):  rdNext = frameR;
      ADDR_W'(OFF_TXD):    rdNext = {txFull, 31'd0};
      ADDR_W'(OFF_RXD):    rdNext = rxEmpty ? 32'h8000_0000 : 32'(rxHead);
      ADDR_W'(OFF_TXMARK): rdNext = 32'(txMarkR);
      ADDR_W'(OFF_RXMARK): rdNext = 32'(rxMarkR);
      ADDR_W'(OFF_IEN):    rdNext = 32'(ienR);
      ADDR_W'(OFF_IPEND):  rdNext = 32'(pendVec);
      default:             rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)     busRdata <= '0;
    else if (rdEn) busRdata <= rdNext;
  end

  // chip-select lines
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_comb begin
      csN[i] = csDefR[i];
      if ((csModeR == 2'd0) && (csIdR == CSID_W'(i)) && engBusy) csN[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spih_top.sv
module spih_top #(
  parameter int NUM_CS     = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 12,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN,
  output logic              irq
);
  import spih_pkg::*;
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  ctrlStrb_t         strb;
  logic [DIV_W-1:0]  sckDiv;
  logic              rxDiscard, txFull, rxEmpty, engBusy, rxPush;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [BYTE_W-1:0] rxHead;

  spih_ctrl #(.NUM_CS(NUM_CS), .DEPTH(FIFO_DEPTH), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .engBusy(engBusy),
    .strb(strb), .sckDiv(sckDiv), .rxDiscard(rxDiscard), .csN(csN), .irq(irq)
  );

  spih_datapath #(.DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) uData (
    .clk(clk), .rstN(rstN),
    .strb(strb), .sckDiv(sckDiv), .rxDiscard(rxDiscard), .miso(miso),
    .sclk(sclk), .mosi(mosi),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .engBusy(engBusy), .rxPush(rxPush)
  );
endmodule

// File: rtl/spih_chk.sv
module spih_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busValid,
  input logic                       busWrite,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [31:0]                busRdata,
  input logic [$clog2(DEPTH+1)-1:0] txCount,
  input logic [$clog2(DEPTH+1)-1:0] rxCount,
  input logic                       engBusy,
  input logic                       rxPush,
  input logic                       sclk
);
  import spih_pkg::*;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic rdTx, rdRx, wrTx;
  assign rdTx = busValid && !busWrite && (busAddr == ADDR_W'(OFF_TXD));
  assign rdRx = busValid && !busWrite && (busAddr == ADDR_W'(OFF_RXD));
  assign wrTx = busValid && busWrite && (busAddr == ADDR_W'(OFF_TXD));

  // R2 R5
  always @(posedge clk) begin
    if (rstN) begin
      fifo_bound_chk: assert (txCount <= CNT_W'(DEPTH) && rxCount <= CNT_W'(DEPTH))
        else $error("fifo count above depth");
    end
  end

  // R2
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTx && (txCount == CNT_W'(DEPTH)) && engBusy |=> txCount == CNT_W'(DEPTH));

  // R2
  tx_full_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdTx && (txCount == CNT_W'(DEPTH)) |=> busRdata == 32'h8000_0000);

  // R3
  rx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdRx && (rxCount == '0) |=> busRdata == 32'h8000_0000);

  // R3
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdRx && (rxCount != '0) && !rxPush |=> rxCount == CNT_W'($past(rxCount) - 1'b1));

  // R3
  rx_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdRx && (rxCount != '0) |=> busRdata[31:BYTE_W] == '0);

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engBusy |-> !sclk);
endmodule

bind spih_top spih_chk #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .txCount(txCount), .rxCount(rxCount),
  .engBusy(engBusy), .rxPush(rxPush), .sclk(sclk)
);

// File: tb/tb_spih_top.sv
module tb_spih_top;
  localparam int NCS   = 2;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, miso, irq;
  logic [NCS-1:0] csN;
  logic        invertMiso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;
  assign miso = invertMiso ^ mosi;

  spih_top #(.NUM_CS(NCS), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN), .irq(irq)
  );

  // serial monitors
  logic [7:0] capSh = '0;
  int hiRun = 0, lastHi = 0;
  always @(posedge sclk) capSh <= {capSh[6:0], mosi};
  always @(negedge clk) begin
    if (sclk) hiRun = hiRun + 1;
    else if (hiRun != 0) begin lastHi = hiRun; hiRun = 0; end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] r;
    busRd(a, r);
    chk(tag, r, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected-value functions from the requirements
  function automatic logic [31:0] markNext(input logic [31:0] old, input logic [31:0] v);
    return (v < DEPTH) ? v : old;
  endfunction
  function automatic logic [31:0] csidNext(input logic [31:0] old, input logic [31:0] v);
    return (v < NCS) ? v : old;
  endfunction
  function automatic logic [31:0] csdefNext(input logic [31:0] old, input logic [31:0] v);
    return (v < (1 << NCS)) ? v : old;
  endfunction
  function automatic logic [31:0] csmodeNext(input logic [31:0] old, input logic [31:0] v);
    return (v <= 3) ? v : old;
  endfunction
  function automatic logic [11:0] deadOff(input int i);
    case (i)
      0: return 12'h008;  1: return 12'h00C;  2: return 12'h01C;  3: return 12'h020;
      4: return 12'h024;  5: return 12'h030;  6: return 12'h034;  7: return 12'h038;
      8: return 12'h03C;  9: return 12'h044; 10: return 12'h058; 11: return 12'h05C;
      12: return 12'h068; 13: return 12'h06C; 14: return 12'h060; 15: return 12'h064;
      16: return 12'h080; default: return 12'hFFC;
    endcase
  endfunction
  function automatic int byteTime(input int n, input int div);
    return n * (16 * (div + 1) + 2) + 10;
  endfunction

  // send n random bytes in loopback, then drain and compare
  task automatic xfer(input int n, input int div, input logic inv);
    logic [7:0]  b [8];
    logic [31:0] r;
    busWr(12'h000, div);
    invertMiso = inv;
    for (int i = 0; i < n; i++) begin
      b[i] = 8'($urandom);
      busWr(12'h048, {24'hA5C3E1, b[i]});   // R2: only low byte is sent
    end
    idle(byteTime(n, div));
    for (int i = 0; i < n; i++) begin
      busRd(12'h04C, r);
      chk("R3 rx byte", r, {24'd0, inv ? ~b[i] : b[i]});
    end
    rdChk("R3 rx empty", 12'h04C, 32'h8000_0000);
    chk("R4 msb first", {24'd0, capSh}, {24'd0, b[n-1]});
    chk("R4 half period", lastHi, div + 1);
    invertMiso = 1'b0;
  endtask

  initial begin
    logic [31:0] eTxM, eRxM, eCsid, eCsdef, eCsmode, v, r;
    int k, sel, txm, rxm, ien;
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdChk("R1 div", 12'h000, 32'h3);
    rdChk("R1 sck mode", 12'h004, 32'h0);
    rdChk("R1 csid", 12'h010, 32'h0);
    rdChk("R1 csdef", 12'h014, 32'h3);
    rdChk("R1 csmode", 12'h018, 32'h0);
    rdChk("R1 delay0", 12'h028, 32'h1001);
    rdChk("R1 delay1", 12'h02C, 32'h1);
    rdChk("R1 frame", 12'h040, 32'h0);
    rdChk("R1 tx status", 12'h048, 32'h0);
    rdChk("R1 rx empty", 12'h04C, 32'h8000_0000);
    rdChk("R1 txmark", 12'h050, 32'h0);
    rdChk("R1 rxmark", 12'h054, 32'h0);
    rdChk("R1 ien", 12'h070, 32'h0);
    rdChk("R1 pend", 12'h074, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 csN", {30'd0, csN}, 32'h3);
    chk("R12 read data held", busRdata, 32'h0);

    // R8 R9 R10: random configuration writes against a model
    eTxM = 0; eRxM = 0; eCsid = 0; eCsdef = 3; eCsmode = 0;
    for (int it = 0; it < 60; it++) begin
      sel = $urandom_range(0, 5);
      case (sel)
        0: begin v = $urandom_range(0, 12); busWr(12'h050, v); eTxM = markNext(eTxM, v);
             rdChk("R8 txmark", 12'h050, eTxM); end
        1: begin v = $urandom_range(0, 12); busWr(12'h054, v); eRxM = markNext(eRxM, v);
             rdChk("R8 rxmark", 12'h054, eRxM); end
        2: begin v = $urandom_range(0, 4); busWr(12'h010, v); eCsid = csidNext(eCsid, v);
             rdChk("R9 csid", 12'h010, eCsid); end
        3: begin v = $urandom_range(0, 6); busWr(12'h014, v); eCsdef = csdefNext(eCsdef, v);
             rdChk("R9 csdef", 12'h014, eCsdef); end
        4: begin v = $urandom_range(0, 6); busWr(12'h018, v); eCsmode = csmodeNext(eCsmode, v);
             rdChk("R9 csmode", 12'h018, eCsmode); end
        default: begin
             k = $urandom_range(0, 17);
             busWr(deadOff(k), $urandom);
             rdChk("R10 dead offset", deadOff(k), 32'h0);
           end
      endcase
    end
    busWr(12'h050, 0); busWr(12'h054, 0);
    busWr(12'h010, 0); busWr(12'h014, 3); busWr(12'h018, 0);

    // R3 R4 R2: random loopback transfers
    for (int it = 0; it < 10; it++)
      xfer($urandom_range(1, 8), $urandom_range(0, 3), 1'($urandom));

    // R8: write to rx data and pending is ignored
    busWr(12'h000, 0);
    busWr(12'h048, 32'h5A);
    idle(byteTime(1, 0));
    busWr(12'h04C, 32'h33);
    busWr(12'h074, 32'h3);
    rdChk("R8 pend write ignored", 12'h074, 32'h2);
    rdChk("R8 rx write ignored", 12'h04C, 32'h5A);

    // R5: receive discard via frame bit 3
    busWr(12'h040, 32'h8);
    busWr(12'h048, 32'h77);
    idle(byteTime(1, 0));
    rdChk("R5 discard", 12'h04C, 32'h8000_0000);
    busWr(12'h040, 32'h0);

    // R2 R5: tx full and rx overflow, slow clock
    busWr(12'h000, 7);
    for (int i = 0; i < 10; i++) busWr(12'h048, 32'h10 + i);
    rdChk("R2 tx full", 12'h048, 32'h8000_0000);
    idle(byteTime(10, 7));
    rdChk("R2 tx drained", 12'h048, 32'h0);
    for (int i = 0; i < 8; i++) rdChk("R5 rx kept", 12'h04C, 32'h10 + i);
    rdChk("R5 rx overflow dropped", 12'h04C, 32'h8000_0000);

    // R6 R7: random watermarks
    busWr(12'h000, 0);
    for (int it = 0; it < 8; it++) begin
      k = $urandom_range(0, 8);
      for (int i = 0; i < k; i++) busWr(12'h048, i);
      idle(byteTime(k, 0));
      txm = $urandom_range(0, 7); rxm = $urandom_range(0, 7); ien = $urandom_range(0, 3);
      busWr(12'h050, txm); busWr(12'h054, rxm); busWr(12'h070, ien);
      v = {30'd0, k > rxm, txm > 0};
      rdChk("R6 pending", 12'h074, v);
      chk("R7 irq", {31'd0, irq}, {31'd0, |(v[1:0] & 2'(ien))});
      for (int i = 0; i < k; i++) busRd(12'h04C, r);
    end
    busWr(12'h070, 0);

    // R11: chip selects
    busWr(12'h000, 3); busWr(12'h014, 3); busWr(12'h010, 1); busWr(12'h018, 0);
    busWr(12'h048, 32'hC3);
    idle(10);
    chk("R11 auto line1 low", {30'd0, csN}, 32'h1);
    idle(byteTime(1, 3));
    chk("R11 idle high", {30'd0, csN}, 32'h3);
    busWr(12'h010, 0);
    busWr(12'h048, 32'h3C);
    idle(10);
    chk("R11 auto line0 low", {30'd0, csN}, 32'h2);
    idle(byteTime(1, 3));
    busWr(12'h018, 2);
    busWr(12'h048, 32'h81);
    idle(10);
    chk("R11 non-auto follows default", {30'd0, csN}, 32'h3);
    idle(byteTime(1, 3));
    busWr(12'h014, 1);
    chk("R11 default drives lines", {30'd0, csN}, 32'h1);

    report();
  end
endmodule